// File: doc/BRIEF.md
# Input Change Watch and Interrupt Combiner

This block watches a seven-bit general input port and folds eight interrupt
conditions into one active-low request line. The four lowest port pins are
synchronised and filtered: a pin must hold a new level at two consecutive
sample ticks before the block accepts it. Each accepted change sets a sticky
delta flag, and those flags stay set until software reads the change register.

The eight conditions are: any input change, a counter event, receive-ready and
transmit-ready for two channels, and a break-change event for each channel.
Ready conditions are levels that follow their source, so they drop when the
source drops (after the receive data is read or the transmit data written).
Break and counter events are sticky pulses that are removed only by their own
clear command. A mask register selects which status bits may pull the request
line low. Status bits stay visible whether masked or not.

Top module: `port_change_irq`

## Requirements
- R1: After reset the status is 0x00, the mask is 0x00, the request line `irq_n_o` is high, all delta flags are clear and the four filtered levels are 1.
- R2: A read at address 3 returns the seven synchronised port pins in bits 6:0 with bit 7 zero, valid two clocks after the pins settle.
- R3: A filtered level changes only at a sample tick, and only when the pin has differed from the filtered level at two consecutive ticks; a pin that returns before the second tick sets no delta.
- R4: The change register (`change_o`, read at address 2) holds the filtered levels of pins 3:0 in bits 3:0 and the sticky delta flags in bits 7:4; a read at address 2 clears the flags unless a new change lands in that same cycle.
- R5: Status bit 0 is set while any delta flag is set and is removed by reading the change register.
- R6: Receive-ready of channels 0 and 1 shows in status bits 2 and 5, transmit-ready in bits 3 and 6, one clock after the ready input.
- R7: A break event on channel 0 or 1 sets status bit 4 or 7, which stays set until that channel's break clear command; the other channel's clear has no effect on it.
- R8: A counter event sets status bit 1, which stays set until the stop-counter command.
- R9: `irq_n_o` is low exactly when some status bit and its mask bit are both 1; the mask is written at address 1, and clearing a mask bit releases the line in the next cycle.
- R10: A masked-off source still shows its status bit at `status_o` and at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 7 | Raw general input port pins |
| sample_tick_i | input | 1 | One-cycle pulse that paces the change filter |
| rx_rdy_i | input | 2 | Receive-ready level per channel |
| tx_rdy_i | input | 2 | Transmit-ready level per channel |
| brk_evt_i | input | 2 | Break-change event pulse per channel |
| brk_clr_i | input | 2 | Break-change clear command per channel |
| ctr_evt_i | input | 1 | Counter event pulse |
| ctr_stop_i | input | 1 | Stop-counter command |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 change, 3 port |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the addressed register |
| status_o | output | 8 | Interrupt status bits |
| change_o | output | 8 | Delta flags (7:4) and filtered levels (3:0) |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a pin that moves away and returns between two sample ticks, since it must leave neither a level change nor a delta. The bench owns the tick, so it moves a pin, gives one tick, restores the pin, lets the synchroniser settle and then gives two more ticks before reading the change register. A second hard case is telling a masked source from an absent one. The bench holds a ready input with its mask bit clear and checks both the high request line and the set status bit.

// File: rtl/pci_pkg.sv
package pci_pkg;
    // register addresses
    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_CHG  = 2'd2;
    localparam logic [1:0] ADDR_PORT = 2'd3;

    // status bit positions
    localparam int IB_CHG  = 0;
    localparam int IB_CTR  = 1;
    localparam int IB_RX0  = 2;
    localparam int IB_TX0  = 3;
    localparam int IB_BRK0 = 4;
    localparam int IB_RX1  = 5;
    localparam int IB_TX1  = 6;
    localparam int IB_BRK1 = 7;

    localparam int DATA_W  = 8;
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;   // pins idle high
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pci_cos.sv
module pci_cos #(
    parameter int N     = 4,
    parameter int TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic         tick_i,
    input  logic         clr_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] delta_o,
    output logic [N-1:0] set_o
);
    localparam int CW = $clog2(TICKS + 1);

    typedef struct packed {
        logic [N-1:0]         level;
        logic [N-1:0]         delta;
        logic [N-1:0][CW-1:0] cnt;
    } cos_t;

    cos_t st_d, st_q;
    logic [N-1:0] set_d;

    always_comb begin
        st_d  = st_q;
        set_d = '0;
        if (clr_i) st_d.delta = '0;
        if (tick_i) begin
            for (int i = 0; i < N; i++) begin
                if (lvl_i[i] != st_q.level[i]) begin
                    if (st_q.cnt[i] == CW'(TICKS - 1)) begin
                        st_d.level[i] = lvl_i[i];
                        st_d.delta[i] = 1'b1;   // new change beats a clear
                        st_d.cnt[i]   = '0;
                        set_d[i]      = 1'b1;
                    end else begin
                        st_d.cnt[i] = st_q.cnt[i] + CW'(1);
                    end
                end else begin
                    st_d.cnt[i] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.level <= '1;
            st_q.delta <= '0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign delta_o = st_q.delta;
    assign set_o   = set_d;
endmodule

// File: rtl/pci_irq.sv
module pci_irq
    import pci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_any_i,
    input  logic [1:0]        rx_rdy_i,
    input  logic [1:0]        tx_rdy_i,
    input  logic [1:0]        brk_evt_i,
    input  logic [1:0]        brk_clr_i,
    input  logic              ctr_evt_i,
    input  logic              ctr_stop_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_n_o
);
    typedef struct packed {
        logic [1:0]        rx;
        logic [1:0]        tx;
        logic [1:0]        brk;
        logic              ctr;
        logic [DATA_W-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rx = rx_rdy_i;
        st_d.tx = tx_rdy_i;
        for (int c = 0; c < 2; c++) begin
            st_d.brk[c] = (st_q.brk[c] & ~brk_clr_i[c]) | brk_evt_i[c];
        end
        st_d.ctr = (st_q.ctr & ~ctr_stop_i) | ctr_evt_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o          = '0;
        status_o[IB_CHG]  = chg_any_i;
        status_o[IB_CTR]  = st_q.ctr;
        status_o[IB_RX0]  = st_q.rx[0];
        status_o[IB_TX0]  = st_q.tx[0];
        status_o[IB_BRK0] = st_q.brk[0];
        status_o[IB_RX1]  = st_q.rx[1];
        status_o[IB_TX1]  = st_q.tx[1];
        status_o[IB_BRK1] = st_q.brk[1];
    end

    assign mask_o  = st_q.mask;
    assign irq_n_o = ~|(status_o & st_q.mask);
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import pci_pkg::*;
#(
    parameter int PORT_W       = 7,
    parameter int COS_N        = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int STABLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pins_i,
    input  logic              sample_tick_i,
    input  logic [1:0]        rx_rdy_i,
    input  logic [1:0]        tx_rdy_i,
    input  logic [1:0]        brk_evt_i,
    input  logic [1:0]        brk_clr_i,
    input  logic              ctr_evt_i,
    input  logic              ctr_stop_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [DATA_W-1:0] status_o,
    output logic [2*COS_N-1:0] change_o,
    output logic              irq_n_o
);
    logic [PORT_W-1:0] port_q;
    logic [COS_N-1:0]  cos_level, cos_delta, cos_set;
    logic [DATA_W-1:0] mask_q;
    logic              chg_clr, mask_we;

    assign chg_clr = reg_rd_i && (reg_addr_i == ADDR_CHG);
    assign mask_we = reg_wr_i && (reg_addr_i == ADDR_MASK);

    pci_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (port_q)
    );

    pci_cos #(.N(COS_N), .TICKS(STABLE_TICKS)) u_cos (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (port_q[COS_N-1:0]),
        .tick_i  (sample_tick_i),
        .clr_i   (chg_clr),
        .level_o (cos_level),
        .delta_o (cos_delta),
        .set_o   (cos_set)
    );

    pci_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .chg_any_i    (|cos_delta),
        .rx_rdy_i     (rx_rdy_i),
        .tx_rdy_i     (tx_rdy_i),
        .brk_evt_i    (brk_evt_i),
        .brk_clr_i    (brk_clr_i),
        .ctr_evt_i    (ctr_evt_i),
        .ctr_stop_i   (ctr_stop_i),
        .mask_we_i    (mask_we),
        .mask_wdata_i (reg_wdata_i),
        .status_o     (status_o),
        .mask_o       (mask_q),
        .irq_n_o      (irq_n_o)
    );

    assign change_o = {cos_delta, cos_level};

    always_comb begin
        case (reg_addr_i)
            ADDR_STAT: reg_rdata_o = status_o;
            ADDR_MASK: reg_rdata_o = mask_q;
            ADDR_CHG:  reg_rdata_o = DATA_W'(change_o);
            default:   reg_rdata_o = DATA_W'(port_q);
        endcase
    end
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
    parameter int COS_N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_tick_i,
    input logic [1:0]         rx_rdy_i,
    input logic [1:0]         brk_evt_i,
    input logic [1:0]         brk_clr_i,
    input logic               ctr_evt_i,
    input logic               ctr_stop_i,
    input logic               reg_rd_i,
    input logic               reg_wr_i,
    input logic [1:0]         reg_addr_i,
    input logic [7:0]         reg_wdata_i,
    input logic [7:0]         status_o,
    input logic [2*COS_N-1:0] change_o,
    input logic               irq_n_o,
    input logic [COS_N-1:0]   cos_set
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == 8'h00 && irq_n_o));

    assert_level_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick_i |=> $stable(change_o[COS_N-1:0]));

    assert_delta_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|change_o[2*COS_N-1:COS_N]) |-> $past(sample_tick_i));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == 2'd2 && cos_set == '0)
        |=> change_o[2*COS_N-1:COS_N] == '0);

    assert_delta_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_i && reg_addr_i == 2'd2)
        |=> ((change_o[2*COS_N-1:COS_N] & $past(change_o[2*COS_N-1:COS_N]))
             == $past(change_o[2*COS_N-1:COS_N])));

    assert_rx0_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy_i[0] |=> status_o[2]);

    assert_rx1_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy_i[1] |=> status_o[5]);

    assert_brk0_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr_i[0] && !brk_evt_i[0]) |=> !status_o[4]);

    assert_brk1_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr_i[1] && !brk_evt_i[1]) |=> !status_o[7]);

    assert_ctr_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_stop_i && !ctr_evt_i) |=> !status_o[1]);

    assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd1 && reg_wdata_i == 8'h00) |=> irq_n_o);
endmodule

bind port_change_irq port_change_irq_chk #(.COS_N(COS_N)) u_chk (.*);

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pins = 7'h7F;
    logic       tick = 1'b0;
    logic [1:0] rx_rdy = 2'b00, tx_rdy = 2'b00;
    logic [1:0] brk_evt = 2'b00, brk_clr = 2'b00;
    logic       ctr_evt = 1'b0, ctr_stop = 1'b0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, status, change;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    port_change_irq u_port_change_irq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sample_tick_i(tick),
        .rx_rdy_i(rx_rdy), .tx_rdy_i(tx_rdy), .brk_evt_i(brk_evt),
        .brk_clr_i(brk_clr), .ctr_evt_i(ctr_evt), .ctr_stop_i(ctr_stop),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .status_o(status), .change_o(change),
        .irq_n_o(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        idle(1);
        chk("R1 status", status, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 change", change, 8'h0F);
        rd_reg(2'd1, d);
        chk("R1 mask", d, 8'h00);
    endtask

    task automatic t_port_and_filter();
        logic [7:0] d;
        @(negedge clk); pins = 7'h55;
        idle(3);
        rd_reg(2'd3, d);
        chk("R2 port read", d, 8'h55);
        pulse_tick();
        chk("R3 one tick no change", change, 8'h0F);
        pulse_tick();
        chk("R3 R4 two ticks accepted", change, 8'hA5);
        chk("R5 R10 status bit0 masked visible", status, 8'h01);
        chk("R10 irq stays high when masked", {7'd0, irq_n}, 8'h01);
        rd_reg(2'd2, d);
        chk("R4 change read", d, 8'hA5);
        chk("R4 R5 flags cleared", change, 8'h05);
        chk("R5 status cleared", status, 8'h00);
    endtask

    task automatic t_glitch();
        @(negedge clk); pins = 7'h54;
        idle(3);
        pulse_tick();
        @(negedge clk); pins = 7'h55;
        idle(3);
        pulse_tick();
        pulse_tick();
        chk("R3 glitch ignored", change, 8'h05);
    endtask

    task automatic t_ready();
        @(negedge clk); rx_rdy = 2'b01; tx_rdy = 2'b10;
        @(negedge clk);
        chk("R6 ready bits", status, 8'h44);
        rx_rdy = 2'b10; tx_rdy = 2'b01;
        @(negedge clk);
        chk("R6 ready swap", status, 8'h28);
        rx_rdy = 2'b00; tx_rdy = 2'b00;
        @(negedge clk);
        chk("R6 ready drop", status, 8'h00);
    endtask

    task automatic t_mask();
        wr_reg(2'd1, 8'h04);
        rx_rdy = 2'b01;
        @(negedge clk);
        chk("R9 irq asserted", {7'd0, irq_n}, 8'h00);
        wr_reg(2'd1, 8'h00);
        chk("R9 mask clear releases", {7'd0, irq_n}, 8'h01);
        chk("R10 status kept", status, 8'h04);
        rx_rdy = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_break();
        @(negedge clk); brk_evt = 2'b10;
        @(negedge clk); brk_evt = 2'b00;
        idle(3);
        chk("R7 break1 sticky", status, 8'h80);
        @(negedge clk); brk_clr = 2'b01;
        @(negedge clk); brk_clr = 2'b00;
        chk("R7 other clear no effect", status, 8'h80);
        @(negedge clk); brk_clr = 2'b10;
        @(negedge clk); brk_clr = 2'b00;
        chk("R7 break1 cleared", status, 8'h00);
    endtask

    task automatic t_counter();
        wr_reg(2'd1, 8'h02);
        @(negedge clk); ctr_evt = 1'b1;
        @(negedge clk); ctr_evt = 1'b0;
        idle(2);
        chk("R8 counter set", status, 8'h02);
        chk("R8 R9 counter irq", {7'd0, irq_n}, 8'h00);
        @(negedge clk); ctr_stop = 1'b1;
        @(negedge clk); ctr_stop = 1'b0;
        chk("R8 counter stopped", status, 8'h00);
        chk("R8 irq released", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_change_irq();
        logic [7:0] d;
        wr_reg(2'd1, 8'h01);
        @(negedge clk); pins = 7'h5F;
        idle(3);
        pulse_tick();
        pulse_tick();
        chk("R5 change irq", {7'd0, irq_n}, 8'h00);
        rd_reg(2'd2, d);
        chk("R4 change read 2", d, 8'hAF);
        chk("R5 irq removed by read", {7'd0, irq_n}, 8'h01);
        @(negedge clk); pins = 7'h7F;
        idle(3);
        rd_reg(2'd3, d);
        chk("R2 port read 2", d, 8'h7F);
        chk("R3 no tick no change", change, 8'h0F);
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_port_and_filter();
        t_glitch();
        t_ready();
        t_mask();
        t_break();
        t_counter();
        t_change_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule